// File: doc/BRIEF.md
# Gate Driver Protection Controller

This block is the digital control core for one side of an isolated power-switch gate driver. It turns a logic-level drive command into a gate-enable signal and guards the power device with four digitised comparator flags: a current-sense trip, a positive-supply undervoltage, a negative-supply undervoltage and an excessive supply difference. Beside the gate enable it drives the switch that shorts the sense input to its Kelvin reference, the enable of the negative-supply charge-pump clock, and an active-low fault status.

Protection follows two policies. An overcurrent trip is recognised only while the gate is on. Once seen, it turns the gate off and stays latched until the command shows a fresh rising edge. An undervoltage on either supply does not latch: it holds the gate off and the fault status low only while the condition lasts. When it clears, the gate comes back on if the command is still high, with no new edge needed. Every input passes through a synchroniser (two flops by default), so every input change reaches the registered outputs on the third rising clock edge after it is applied.

Top module: `gdrv_guard`

## Requirements
- R1: With no fault present, the gate enable follows the command: it becomes high (or low) at the third rising clock edge after the command input goes high (or low).
- R2: A current-sense trip that occurs while the gate enable is low has no effect: the gate stays low and the fault status stays high.
- R3: A current-sense trip that occurs while the gate enable is high forces the gate enable low and the fault status low at the third clock edge. Both stay low, whatever the command level, until the command has a fresh rising edge, which clears the latch.
- R4: An undervoltage on either the positive supply or the negative supply forces the gate enable low and the fault status low. This holds for as long as the flag is set. When the flag clears, both recover, and the gate comes back on if the command is still high.
- R5: During reset and after reset, the gate enable and the fault status are low and the sense-short control is high. The fault status rises only when both undervoltage flags have been seen clear, at the third edge after reset release.
- R6: The sense-short control is high whenever the gate enable is low, and low whenever the gate enable is high.
- R7: The fault status is low exactly when an overcurrent is latched or an undervoltage is present at the synchroniser output.
- R8: The charge-pump clock enable is low from the third edge after the supply-difference flag is raised and high again three edges after it drops.
- R9: A rising command edge that arrives during an undervoltage does not turn the gate on. The gate turns on once the undervoltage has cleared, if the command is still high, including when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | Drive command, asynchronous |
| oc_trip_i | input | 1 | Current-sense comparator trip, asynchronous |
| uv_pos_i | input | 1 | Positive-supply undervoltage flag, asynchronous |
| uv_neg_i | input | 1 | Negative-supply undervoltage flag, asynchronous |
| sup_over_i | input | 1 | Supply difference excessive flag, asynchronous |
| gate_en_o | output | 1 | Gate enable to the output stage |
| sense_short_o | output | 1 | Closes the switch that shorts the sense input to Kelvin ground |
| pump_en_o | output | 1 | Charge-pump clock enable |
| fault_n_o | output | 1 | Fault status, active low |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked on purpose. In the first pair, an undervoltage clears in the same input vector in which the command rises. This checks that the edge is neither lost nor needs repeating, and the gate must be on three edges later. In the second pair, a current-sense trip arrives in the same vector as an undervoltage onset while the gate is on. The overcurrent must still latch, so after the undervoltage clears the gate stays off and the fault status stays low until the next rising command edge. A long pseudo-random sweep also hits other overlaps, and every cycle is compared against a three-edge-delayed model of the requirements.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

    // Width and bit positions of the flag bundle that the synchroniser carries.
    localparam int FLAG_W  = 5;
    localparam int IDX_CMD = 4;
    localparam int IDX_OC  = 3;
    localparam int IDX_UVP = 2;
    localparam int IDX_UVN = 1;
    localparam int IDX_SDX = 0;

    // Reset image of the synchroniser: both supplies are assumed bad
    // until their flags have travelled through the chain.
    localparam logic [FLAG_W-1:0] SYNC_RST_IMAGE =
        (FLAG_W'(1) << IDX_UVP) | (FLAG_W'(1) << IDX_UVN);

    typedef struct packed {
        logic oc_latched;
        logic cmd_prev;
    } trip_state_t;

    typedef struct packed {
        logic gate;
        logic short_sw;
        logic fault_n;
        logic pump;
    } drive_state_t;

    localparam trip_state_t  TRIP_RST  = '{oc_latched: 1'b0, cmd_prev: 1'b0};
    localparam drive_state_t DRIVE_RST = '{gate: 1'b0, short_sw: 1'b1,
                                           fault_n: 1'b0, pump: 1'b0};

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/gdrv_trip.sv
module gdrv_trip
    import gdrv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    input  logic oc_s,
    input  logic gate_on,
    output logic oc_next
);

    trip_state_t st_d, st_q;
    logic        cmd_rise;

    always_comb begin
        st_d          = st_q;
        cmd_rise      = cmd_s & ~st_q.cmd_prev;
        st_d.cmd_prev = cmd_s;
        if (cmd_rise) begin
            // A fresh turn-on request clears a held overcurrent.
            st_d.oc_latched = 1'b0;
        end else if (gate_on && oc_s) begin
            // Sense input counts only while the device is driven on.
            st_d.oc_latched = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TRIP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign oc_next = st_d.oc_latched;

endmodule

// File: rtl/gdrv_drive.sv
module gdrv_drive
    import gdrv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_s,
    input  logic uv_s,
    input  logic oc_next,
    input  logic sdx_s,
    output logic gate_o,
    output logic short_o,
    output logic fault_n_o,
    output logic pump_o
);

    drive_state_t dr_d, dr_q;

    always_comb begin
        dr_d          = dr_q;
        dr_d.gate     = cmd_s & ~uv_s & ~oc_next;
        dr_d.short_sw = ~dr_d.gate;
        dr_d.fault_n  = ~(uv_s | oc_next);
        dr_d.pump     = ~sdx_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= DRIVE_RST;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign gate_o    = dr_q.gate;
    assign short_o   = dr_q.short_sw;
    assign fault_n_o = dr_q.fault_n;
    assign pump_o    = dr_q.pump;

endmodule

// File: rtl/gdrv_guard.sv
module gdrv_guard
    import gdrv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_i,
    input  logic oc_trip_i,
    input  logic uv_pos_i,
    input  logic uv_neg_i,
    input  logic sup_over_i,
    output logic gate_en_o,
    output logic sense_short_o,
    output logic pump_en_o,
    output logic fault_n_o
);

    logic [FLAG_W-1:0] flags_raw, flags_s;
    logic cmd_s, oc_s, uv_s, sdx_s;
    logic oc_next;

    always_comb begin
        flags_raw          = '0;
        flags_raw[IDX_CMD] = cmd_i;
        flags_raw[IDX_OC]  = oc_trip_i;
        flags_raw[IDX_UVP] = uv_pos_i;
        flags_raw[IDX_UVN] = uv_neg_i;
        flags_raw[IDX_SDX] = sup_over_i;
    end

    gdrv_sync #(
        .W       (FLAG_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST_IMAGE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (flags_raw),
        .sync_o  (flags_s)
    );

    assign cmd_s = flags_s[IDX_CMD];
    assign oc_s  = flags_s[IDX_OC];
    assign uv_s  = flags_s[IDX_UVP] | flags_s[IDX_UVN];
    assign sdx_s = flags_s[IDX_SDX];

    gdrv_trip u_trip (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_s   (cmd_s),
        .oc_s    (oc_s),
        .gate_on (gate_en_o),
        .oc_next (oc_next)
    );

    gdrv_drive u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_s     (cmd_s),
        .uv_s      (uv_s),
        .oc_next   (oc_next),
        .sdx_s     (sdx_s),
        .gate_o    (gate_en_o),
        .short_o   (sense_short_o),
        .fault_n_o (fault_n_o),
        .pump_o    (pump_en_o)
    );

endmodule

// File: rtl/gdrv_guard_chk.sv
module gdrv_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_s,
    input logic oc_s,
    input logic uv_s,
    input logic sdx_s,
    input logic gate_en_o,
    input logic fault_n_o,
    input logic pump_en_o
);

    // R1: the gate can only be on if the synchronised command was high.
    p_gate_needs_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        gate_en_o |-> $past(cmd_s));

    // R2: a trip seen while the gate is off leaves the fault status alone.
    p_off_trip_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_en_o && fault_n_o && !uv_s) |=> fault_n_o);

    // R3: a trip while on shuts the gate at the next edge.
    p_trip_shuts_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en_o && oc_s) |=> (!gate_en_o && !fault_n_o));

    // R4: any undervoltage holds the gate off and flags a fault.
    p_uv_blocks_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        uv_s |=> (!gate_en_o && !fault_n_o));

    // R8: the charge-pump enable tracks the supply-difference flag.
    p_pump_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sdx_s |=> !pump_en_o);

    p_pump_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sdx_s |=> pump_en_o);

endmodule

bind gdrv_guard gdrv_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_s     (cmd_s),
    .oc_s      (oc_s),
    .uv_s      (uv_s),
    .sdx_s     (sdx_s),
    .gate_en_o (gate_en_o),
    .fault_n_o (fault_n_o),
    .pump_en_o (pump_en_o)
);

// File: tb/gdrv_guard_tb_top.sv
module gdrv_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;
    localparam int SWEEP_N    = 3000;

    // Input vector layout: [4] command, [3] trip, [2] uv pos, [1] uv neg, [0] supply diff.
    localparam logic [4:0] CMD = 5'b10000;
    localparam logic [4:0] OC  = 5'b01000;
    localparam logic [4:0] UVP = 5'b00100;
    localparam logic [4:0] UVN = 5'b00010;
    localparam logic [4:0] SDX = 5'b00001;
    localparam logic [4:0] NIL = 5'b00000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] vec = '0;
    logic       gate_en, sense_short, pump_en, fault_n;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gdrv_guard dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (vec[4]),
        .oc_trip_i     (vec[3]),
        .uv_pos_i      (vec[2]),
        .uv_neg_i      (vec[1]),
        .sup_over_i    (vec[0]),
        .gate_en_o     (gate_en),
        .sense_short_o (sense_short),
        .pump_en_o     (pump_en),
        .fault_n_o     (fault_n)
    );

    // Requirement model: inputs delayed two edges, then registered outputs.
    logic [4:0] m_s1, m_s2;
    logic m_gate, m_oc, m_prev, m_fn, m_pump;

    always @(posedge clk or negedge rst_n) begin : model
        logic m_uv, m_ocn;
        if (!rst_n) begin
            m_s1 <= UVP | UVN; m_s2 <= UVP | UVN;
            m_gate <= 1'b0; m_oc <= 1'b0; m_prev <= 1'b0;
            m_fn <= 1'b0; m_pump <= 1'b0;
        end else begin
            m_uv  = m_s2[2] | m_s2[1];
            if (m_s2[4] && !m_prev)    m_ocn = 1'b0;
            else if (m_gate && m_s2[3]) m_ocn = 1'b1;
            else                        m_ocn = m_oc;
            m_s1   <= vec;
            m_s2   <= m_s1;
            m_oc   <= m_ocn;
            m_prev <= m_s2[4];
            m_gate <= m_s2[4] & ~m_uv & ~m_ocn;
            m_fn   <= ~(m_uv | m_ocn);
            m_pump <= ~m_s2[0];
        end
    end

    task automatic check_bit(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic tick(input logic [4:0] v);
        @(posedge clk);
        @(negedge clk);
        check_bit(gate_en,     m_gate,  "R1 R3 R4 gate vs model");
        check_bit(sense_short, ~m_gate, "R6 sense short vs model");
        check_bit(fault_n,     m_fn,    "R7 fault status vs model");
        check_bit(pump_en,     m_pump,  "R8 pump enable vs model");
        vec = v;
    endtask

    task automatic hold(input logic [4:0] v, input int n);
        for (int i = 0; i < n; i++) tick(v);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] lf;
        logic        cmd_st;
        vec = NIL;
        repeat (3) @(negedge clk);
        check_bit(gate_en,     1'b0, "R5 gate in reset");
        check_bit(sense_short, 1'b1, "R5 short in reset");
        check_bit(fault_n,     1'b0, "R5 fault in reset");
        check_bit(pump_en,     1'b0, "R5 pump in reset");
        rst_n = 1'b1;

        hold(NIL, 2);
        check_bit(fault_n, 1'b0, "R5 fault before supply seen");
        hold(NIL, 1);
        check_bit(fault_n, 1'b1, "R5 fault after supply seen");

        // R1 latency and turn on
        hold(CMD, 3);
        check_bit(gate_en, 1'b0, "R1 gate not yet on");
        hold(CMD, 1);
        check_bit(gate_en, 1'b1, "R1 gate on");
        check_bit(sense_short, 1'b0, "R6 short released");

        // R3 trip while on, latched
        tick(CMD | OC);
        hold(CMD, 3);
        check_bit(gate_en, 1'b0, "R3 gate off after trip");
        check_bit(fault_n, 1'b0, "R3 fault after trip");
        hold(CMD, 10);
        check_bit(gate_en, 1'b0, "R3 latch holds with command high");
        hold(NIL, 4);
        check_bit(fault_n, 1'b0, "R3 latch holds with command low");
        hold(CMD, 4);
        check_bit(gate_en, 1'b1, "R3 rising edge re-enables");
        check_bit(fault_n, 1'b1, "R3 rising edge clears fault");

        // R2 trip while off
        hold(NIL, 4);
        hold(OC, 6);
        check_bit(gate_en, 1'b0, "R2 gate stays off");
        check_bit(fault_n, 1'b1, "R2 trip ignored while off");
        check_bit(sense_short, 1'b1, "R6 short while off");
        hold(NIL, 3);

        // R4 undervoltage self-clearing
        hold(CMD, 4);
        hold(CMD | UVN, 4);
        check_bit(gate_en, 1'b0, "R4 negative uv forces off");
        check_bit(fault_n, 1'b0, "R4 negative uv fault");
        hold(CMD, 4);
        check_bit(gate_en, 1'b1, "R4 recovers without new edge");
        check_bit(fault_n, 1'b1, "R4 fault cleared");
        hold(CMD | UVP, 4);
        check_bit(gate_en, 1'b0, "R4 positive uv forces off");
        hold(CMD, 4);
        check_bit(gate_en, 1'b1, "R4 positive uv recovery");

        // R9 edge during undervoltage
        hold(NIL, 4);
        hold(UVP, 4);
        check_bit(fault_n, 1'b0, "R7 uv shows on status");
        hold(UVP | CMD, 6);
        check_bit(gate_en, 1'b0, "R9 edge during uv blocked");
        hold(CMD, 4);
        check_bit(gate_en, 1'b1, "R9 gate on after uv clears");

        // R8 pump enable
        hold(CMD | SDX, 4);
        check_bit(pump_en, 1'b0, "R8 pump off");
        check_bit(gate_en, 1'b1, "R8 gate unaffected");
        hold(CMD, 4);
        check_bit(pump_en, 1'b1, "R8 pump back on");

        // Coincidences: uv clears with rising edge; trip with uv onset
        hold(NIL, 4);
        hold(UVP, 4);
        tick(CMD);
        hold(CMD, 3);
        check_bit(gate_en, 1'b1, "R9 uv clear and edge same cycle");
        tick(CMD | OC | UVN);
        hold(CMD, 3);
        check_bit(gate_en, 1'b0, "R3 trip with uv onset");
        hold(CMD, 6);
        check_bit(gate_en, 1'b0, "R3 latch outlives uv");
        check_bit(fault_n, 1'b0, "R7 latched trip on status");

        // Pseudo-random sweep checked every cycle against the model
        lf = 16'hACE1;
        cmd_st = 1'b0;
        for (int i = 0; i < SWEEP_N; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[3:1] == 3'b000) cmd_st = ~cmd_st;
            tick({cmd_st, lf[7:5] == 3'b000, lf[11:8] == 4'h0,
                  lf[15:12] == 4'h0, lf[4] & lf[9] & lf[14]});
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule